// File: doc/BRIEF.md
# Fault Latch Hiccup Soft-Start Sequencer

This block manages start-up and overcurrent recovery for a switching power stage, entirely in the digital domain. An accumulator stands in for a soft-start capacitor. While power is good, the accumulator climbs by a programmable charge step on each rate tick. The requested duty command is clamped to the accumulator value, so the drive ramps up gently and stays bounded by it in steady state.

An overcurrent flag latches a fault and removes drive in the same cycle. If the ramp had already finished, the accumulator drains by a larger programmable discharge step per tick. If the ramp was still rising, it first keeps charging to the full threshold and only then drains. This keeps the hiccup repetition rate bounded when the fault never goes away. The latch releases only once the level is at or below the restart threshold and the overcurrent flag is low. A fresh soft-start then follows.

Losing power-good overrides everything else and returns the block to its idle, cleared state.

Top module: `softstart_fault_seq`

## Requirements
- R1: While pgood_i is low, the next clock edge puts the block in IDLE with ss_level_o equal to 0. drive_en_o is low in any cycle in which pgood_i is low. This takes priority over all fault handling.
- R2: In SOFTSTART, RUN and FAULT_CHARGE_FIRST, each cycle with tick_i high raises ss_level_o by chg_step_i. The result saturates at the all-ones value.
- R3: With ocp_i high, drive_en_o is low and duty_o is 0 in that same cycle. A high ocp_i in SOFTSTART, RUN or IDLE latches a fault on the next edge.
- R4: ocp_i high in RUN leads to FAULT_DISCHARGE. In FAULT_DISCHARGE, each cycle with tick_i high lowers ss_level_o by dis_step_i, saturating at 0.
- R5: ocp_i high in SOFTSTART leads to FAULT_CHARGE_FIRST. The level keeps charging there, and the block moves to FAULT_DISCHARGE only on an edge where the level was at or above full_thr_i.
- R6: FAULT_DISCHARGE returns to SOFTSTART only on an edge where the level was at or below restart_thr_i and ocp_i was low. The level is kept as the start point of the new ramp.
- R7: SOFTSTART moves to RUN on an edge where the level was at or above full_thr_i and ocp_i was low.
- R8: duty_o equals the smaller of duty_req_i and ss_level_o when drive_en_o is high, and 0 otherwise. drive_en_o is high only in SOFTSTART or RUN with pgood_i high and ocp_i low.
- R9: state_o encodes IDLE=0, SOFTSTART=1, RUN=2, FAULT_DISCHARGE=3 and FAULT_CHARGE_FIRST=4. fault_o is high in states 3 and 4. ss_done_o is high in state 2.
- R10: From IDLE with pgood_i high, the next edge goes to FAULT_DISCHARGE if ocp_i is high, and to SOFTSTART otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Rate tick that enables one charge or discharge step |
| pgood_i | input | 1 | Supply and undervoltage check good |
| ocp_i | input | 1 | Overcurrent flag |
| duty_req_i | input | LVL_W | Requested duty command |
| chg_step_i | input | LVL_W | Charge step per tick |
| dis_step_i | input | LVL_W | Discharge step per tick |
| full_thr_i | input | LVL_W | Level that counts as full charge |
| restart_thr_i | input | LVL_W | Level at or below which a fault may release |
| ss_level_o | output | LVL_W | Soft-start accumulator value |
| duty_o | output | LVL_W | Clamped duty command |
| drive_en_o | output | 1 | Drive outputs enabled |
| fault_o | output | 1 | Fault latch set |
| ss_done_o | output | 1 | Soft-start complete, regulating |
| state_o | output | 3 | Sequencer state code |

## Verification
The bench builds the block with LVL_W=10, so the full scale is 1023. A charge step of a few hundred then reaches the all-ones saturation in only a handful of ticks. A discharge step larger than the remaining level shows the floor at zero. With a full threshold near 860 and a charge step of 9, a fault injected mid-ramp leaves a long charge-first window, which exposes any early discharge. Random phases vary the steps and thresholds, the tick density, and the overcurrent bursts. Power-good drops arrive in every state, including during both fault states.

// File: rtl/softstart_fault_seq.sv
module softstart_fault_seq #(
  parameter int LVL_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pgood_i,
  input  logic             ocp_i,
  input  logic [LVL_W-1:0] duty_req_i,
  input  logic [LVL_W-1:0] chg_step_i,
  input  logic [LVL_W-1:0] dis_step_i,
  input  logic [LVL_W-1:0] full_thr_i,
  input  logic [LVL_W-1:0] restart_thr_i,
  output logic [LVL_W-1:0] ss_level_o,
  output logic [LVL_W-1:0] duty_o,
  output logic             drive_en_o,
  output logic             fault_o,
  output logic             ss_done_o,
  output logic [2:0]       state_o
);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RAMP   = 3'd1,
    ST_RUN    = 3'd2,
    ST_DRAIN  = 3'd3,
    ST_FILL   = 3'd4
  } mode_e;

  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  mode_e            state_q, state_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [LVL_W:0]   up_sum;
  logic [LVL_W-1:0] up_sat, dn_sat;
  logic             at_full, at_restart, charging;

  assign up_sum     = {1'b0, lvl_q} + {1'b0, chg_step_i};
  assign up_sat     = up_sum[LVL_W] ? LVL_MAX : up_sum[LVL_W-1:0];
  assign dn_sat     = (lvl_q < dis_step_i) ? '0 : lvl_q - dis_step_i;
  assign at_full    = lvl_q >= full_thr_i;
  assign at_restart = lvl_q <= restart_thr_i;
  assign charging   = (state_q == ST_RAMP) || (state_q == ST_RUN) || (state_q == ST_FILL);

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    if (tick_i && charging)              lvl_d = up_sat;
    if (tick_i && state_q == ST_DRAIN)   lvl_d = dn_sat;
    unique case (state_q)
      ST_IDLE:  state_d = ocp_i ? ST_DRAIN : ST_RAMP;
      ST_RAMP:  if (ocp_i) state_d = ST_FILL;
                else if (at_full) state_d = ST_RUN;
      ST_RUN:   if (ocp_i) state_d = ST_DRAIN;
      ST_FILL:  if (at_full) state_d = ST_DRAIN;
      ST_DRAIN: if (at_restart && !ocp_i) state_d = ST_RAMP;
      default:  state_d = ST_IDLE;
    endcase
    if (!pgood_i) begin
      state_d = ST_IDLE;
      lvl_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
    end
  end

  assign drive_en_o = pgood_i && !ocp_i && (state_q == ST_RAMP || state_q == ST_RUN);
  assign duty_o     = !drive_en_o ? '0 : (duty_req_i < lvl_q) ? duty_req_i : lvl_q;
  assign ss_level_o = lvl_q;
  assign fault_o    = (state_q == ST_DRAIN) || (state_q == ST_FILL);
  assign ss_done_o  = state_q == ST_RUN;
  assign state_o    = state_q;

endmodule

// File: rtl/softstart_fault_seq_chk.sv
module softstart_fault_seq_chk #(
  parameter int LVL_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pgood_i,
  input logic             ocp_i,
  input logic [LVL_W-1:0] restart_thr_i,
  input logic [LVL_W-1:0] ss_level_o,
  input logic [LVL_W-1:0] duty_o,
  input logic             drive_en_o,
  input logic             fault_o,
  input logic [2:0]       state_o
);

  a_r1_pgood_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgood_i |=> (state_o == 3'd0 && ss_level_o == '0));

  a_r3_ocp_blocks_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ocp_i |-> (!drive_en_o && duty_o == '0));

  a_r4_drain_never_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && pgood_i) |=> ss_level_o <= $past(ss_level_o));

  a_r5_fill_never_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && pgood_i) |=> ss_level_o >= $past(ss_level_o));

  a_r6_release_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 3'd3 && state_o == 3'd1)
      |-> ($past(ss_level_o) <= $past(restart_thr_i) && !$past(ocp_i)));

  a_r8_duty_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_o <= ss_level_o);

  a_r9_drive_fault_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({drive_en_o, fault_o}));

endmodule

bind softstart_fault_seq softstart_fault_seq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pgood_i(pgood_i), .ocp_i(ocp_i),
  .restart_thr_i(restart_thr_i), .ss_level_o(ss_level_o), .duty_o(duty_o),
  .drive_en_o(drive_en_o), .fault_o(fault_o), .state_o(state_o)
);

// File: tb/test_softstart_fault_seq.sv
module test_softstart_fault_seq;
  localparam int W   = 10;
  localparam int MAX = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, pgood_i = 1'b0, ocp_i = 1'b0;
  logic [W-1:0] duty_req_i = '0, chg_step_i = '0, dis_step_i = '0;
  logic [W-1:0] full_thr_i = '0, restart_thr_i = '0;
  logic [W-1:0] ss_level_o, duty_o;
  logic drive_en_o, fault_o, ss_done_o;
  logic [2:0] state_o;

  int checks = 0, errors = 0;
  int m_st = 0, m_lvl = 0;

  always #5 clk = ~clk;

  softstart_fault_seq #(.LVL_W(W)) i_softstart_fault_seq (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .pgood_i(pgood_i), .ocp_i(ocp_i),
    .duty_req_i(duty_req_i), .chg_step_i(chg_step_i), .dis_step_i(dis_step_i),
    .full_thr_i(full_thr_i), .restart_thr_i(restart_thr_i),
    .ss_level_o(ss_level_o), .duty_o(duty_o), .drive_en_o(drive_en_o),
    .fault_o(fault_o), .ss_done_o(ss_done_o), .state_o(state_o));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_en();
    return (pgood_i && !ocp_i && (m_st == 1 || m_st == 2)) ? 1 : 0;
  endfunction

  function automatic int exp_duty();
    if (exp_en() == 0) return 0;
    return (int'(duty_req_i) < m_lvl) ? int'(duty_req_i) : m_lvl;
  endfunction

  task automatic compare();
    chk("R9 state", int'(state_o), m_st);
    chk("R2 level", int'(ss_level_o), m_lvl);
    chk("R3 drive_en", int'(drive_en_o), exp_en());
    chk("R8 duty", int'(duty_o), exp_duty());
    chk("R9 fault", int'(fault_o), (m_st == 3 || m_st == 4) ? 1 : 0);
    chk("R9 done", int'(ss_done_o), (m_st == 2) ? 1 : 0);
  endtask

  task automatic model_step();
    int old = m_lvl;
    int nl  = m_lvl;
    int ns  = m_st;
    if (tick_i && (m_st == 1 || m_st == 2 || m_st == 4))
      nl = (old + int'(chg_step_i) > MAX) ? MAX : old + int'(chg_step_i);
    if (tick_i && m_st == 3)
      nl = (old < int'(dis_step_i)) ? 0 : old - int'(dis_step_i);
    case (m_st)
      0: ns = ocp_i ? 3 : 1;
      1: ns = ocp_i ? 4 : (old >= int'(full_thr_i) ? 2 : 1);
      2: ns = ocp_i ? 3 : 2;
      4: ns = (old >= int'(full_thr_i)) ? 3 : 4;
      3: ns = (old <= int'(restart_thr_i) && !ocp_i) ? 1 : 3;
      default: ns = 0;
    endcase
    if (!pgood_i) begin ns = 0; nl = 0; end
    m_st = ns; m_lvl = nl;
  endtask

  task automatic cyc();
    #1;
    compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset state", int'(state_o), 0);
    chk("R1 reset level", int'(ss_level_o), 0);
    chk("R1 reset drive", int'(drive_en_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R10: IDLE with ocp goes to fault drain
    pgood_i = 1; ocp_i = 1; tick_i = 1; chg_step_i = 9; dis_step_i = 250;
    full_thr_i = 860; restart_thr_i = 100; duty_req_i = 500;
    cyc();
    chk("R10 idle+ocp", int'(state_o), 3);
    ocp_i = 0;
    cyc();
    chk("R10 release to ramp", int'(state_o), 1);

    // R5: fault during ramp charges first
    for (int i = 0; i < 20; i++) cyc();
    ocp_i = 1;
    cyc();
    chk("R5 fill state", int'(state_o), 4);
    chk("R3 fault flag", int'(fault_o), 1);
    ocp_i = 0;
    for (int i = 0; i < 200 && m_st == 4; i++) begin
      if (int'(ss_level_o) < 860) chk("R5 stays filling", int'(state_o), 4);
      cyc();
    end
    chk("R5 drain after full", int'(state_o), 3);
    chk("R5 level reached full", (int'(ss_level_o) >= 860) ? 1 : 0, 1);
    // R4 / R6: drain to release
    for (int i = 0; i < 20 && m_st == 3; i++) cyc();
    chk("R6 released", int'(state_o), 1);
    chk("R6 level at or below restart", (int'(ss_level_o) <= 100) ? 1 : 0, 1);

    // R7 then R4 from RUN
    for (int i = 0; i < 200 && m_st == 1; i++) cyc();
    chk("R7 run", int'(state_o), 2);
    ocp_i = 1; cyc(); ocp_i = 0;
    chk("R4 run fault drain", int'(state_o), 3);
    dis_step_i = 1000; cyc();
    chk("R4 drain floors at zero", int'(ss_level_o), 0);
    cyc();

    // R2: saturation at full scale
    chg_step_i = 700; full_thr_i = MAX[W-1:0];
    for (int i = 0; i < 6; i++) cyc();
    chk("R2 saturates", int'(ss_level_o), MAX);

    // R1: pgood drop in a fault state
    ocp_i = 1; cyc(); ocp_i = 0;
    pgood_i = 0; cyc();
    chk("R1 pgood drop idle", int'(state_o), 0);
    chk("R1 pgood drop clears", int'(ss_level_o), 0);
    pgood_i = 1;

    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      chg_step_i    = W'(1 + $urandom_range(0, 60));
      dis_step_i    = W'(50 + $urandom_range(0, 300));
      full_thr_i    = W'(600 + $urandom_range(0, 400));
      restart_thr_i = W'($urandom_range(0, 150));
      for (int c = 0; c < 1200; c++) begin
        tick_i     = ($urandom_range(0, 2) != 0);
        pgood_i    = ($urandom_range(0, 299) != 0);
        if (ocp_i) ocp_i = ($urandom_range(0, 3) != 0);
        else       ocp_i = ($urandom_range(0, 99) == 0);
        duty_req_i = W'($urandom_range(0, MAX));
        cyc();
      end
    end
    report();
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule